// File: doc/BRIEF.md
# Word-by-Halfword Signed Multiply-Accumulate Unit

This datapath unit multiplies a signed word operand by a signed halfword chosen at run time from either half of a second word. The accumulator word is aligned to the upper part of the double-width product, the two are added at full precision, and the unit returns the upper word of that sum. The low halfword of the product never reaches the output.

A sticky saturation flag records any accumulate overflow. The flag stays set across later operations until an external clear pulls it down. Each operation is qualified by a valid bit and a condition-pass bit, and an operation whose condition fails leaves both the result and the flag untouched. The pipeline is two registers deep and its latency does not depend on operand values. Instruction decode, register storage and exception logic sit outside the unit.

With the default parameters the word is 32 bits, the halfword is 16 bits, and the internal product is 48 bits wide.

Top module: `wbm_mac`

## Requirements
- R1: The halfword operand is `in_b[2*H_W-1:H_W]` when `in_half` is 1 and `in_b[H_W-1:0]` when `in_half` is 0. The unselected half of `in_b` has no effect on `res_data` or on `sat_flag`.
- R2: `in_a` and the selected halfword are two's-complement values. `res_data` equals bits `[A_W+H_W-1:H_W]` of `in_a*half + (in_c << H_W)`, with that sum formed at full precision.
- R3: An input is accepted when `in_valid` and `in_cond` are both 1 at a rising edge. Exactly one `res_valid` pulse follows each accepted input, two cycles later, whatever the operand values and the flag state.
- R4: An input with `in_valid` or `in_cond` at 0 produces no `res_valid` pulse and no flag change. `res_data` holds its last value while `res_valid` is 0.
- R5: `sat_flag` becomes 1 in the same cycle as a result for which the full sum shifted arithmetically right by `H_W` differs from `res_data` sign-extended.
- R6: Once set, `sat_flag` stays 1 until `flag_clr` is sampled at 1. It reads 0 in the cycle after the clear when no overflowing result arrives at the same edge.
- R7: When a clear and an overflowing result meet at the same edge, the flag ends at 1.
- R8: A synchronous active-high `rst` brings `res_valid`, `res_data` and `sat_flag` to 0.
- R9: The multiplication alone never overflows. With `in_c` equal to 0, `sat_flag` is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bundle present |
| in_cond | input | 1 | Condition passed; 0 turns the operation into a no-op |
| in_half | input | 1 | Halfword select: 1 upper, 0 lower |
| in_a | input | A_W | Signed word multiplicand |
| in_b | input | 2*H_W | Word holding the halfword multiplier |
| in_c | input | A_W | Signed accumulator word |
| flag_clr | input | 1 | Clears the sticky flag |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | A_W | Upper word of the sum |
| sat_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `rst` is applied before use and that every input carries a defined value on each edge, including the operand buses while `in_valid` is 0. They also treat `flag_clr` as a plain level sampled on every edge. The bench starts with reset, drives every input on the falling edge, and keeps the operand buses filled with real data even in idle or condition-failed cycles. The bench runs a narrowed configuration (6-bit word, 3-bit halfword) and sweeps every multiplicand against every halfword value in both halves. It pairs these with a set of accumulator values that includes zero and both extremes, and fills the unused half with varying bits.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_sel_e;

    // Two's-complement add overflow: the guard bit and the sign bit disagree.
    function automatic logic add_overflow(input logic guard_bit, input logic sign_bit);
        return guard_bit ^ sign_bit;
    endfunction

endpackage

// File: rtl/wbm_half_pick.sv
module wbm_half_pick #(
    parameter int H_W = 16
) (
    input  logic [2*H_W-1:0] word,
    input  logic             sel,
    output logic [H_W-1:0]   half
);
    import wbm_pkg::*;

    half_sel_e sel_e;

    always_comb begin
        sel_e = half_sel_e'(sel);
        if (sel_e == HALF_HIGH) begin
            half = word[2*H_W-1:H_W];
        end else begin
            half = word[H_W-1:0];
        end
    end

endmodule

// File: rtl/wbm_mul_stage.sv
module wbm_mul_stage #(
    parameter int A_W = 32,
    parameter int H_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  logic signed [A_W-1:0] op_a,
    input  logic signed [H_W-1:0] op_h,
    input  logic        [A_W-1:0] op_c,
    output logic                  s1_valid,
    output logic        [A_W-1:0] s1_phi,
    output logic        [A_W-1:0] s1_acc
);
    localparam int P_W = A_W + H_W;

    typedef struct packed {
        logic           valid;
        logic [A_W-1:0] phi;
        logic [A_W-1:0] acc;
    } s1_t;

    s1_t st_d, st_q;
    logic signed [P_W-1:0] prod_full;
    logic                  unused_prod_lo;

    always_comb begin
        prod_full      = P_W'(op_a) * P_W'(op_h);
        unused_prod_lo = ^prod_full[H_W-1:0];
        st_d           = st_q;
        st_d.valid     = fire;
        if (fire) begin
            st_d.phi = prod_full[P_W-1:H_W];
            st_d.acc = op_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid = st_q.valid;
    assign s1_phi   = st_q.phi;
    assign s1_acc   = st_q.acc;

endmodule

// File: rtl/wbm_acc_stage.sv
module wbm_acc_stage #(
    parameter int A_W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           s1_valid,
    input  logic [A_W-1:0] s1_phi,
    input  logic [A_W-1:0] s1_acc,
    output logic           res_valid,
    output logic [A_W-1:0] res_data,
    output logic           res_ovf,
    output logic           set_now
);
    import wbm_pkg::*;

    localparam int S_W = A_W + 1;

    typedef struct packed {
        logic           valid;
        logic [A_W-1:0] data;
        logic           ovf;
    } s2_t;

    s2_t            st_d, st_q;
    logic [S_W-1:0] sum_hi;
    logic           ovf_now;

    always_comb begin
        sum_hi     = {s1_phi[A_W-1], s1_phi} + {s1_acc[A_W-1], s1_acc};
        ovf_now    = add_overflow(sum_hi[S_W-1], sum_hi[S_W-2]);
        set_now    = s1_valid & ovf_now;
        st_d       = st_q;
        st_d.valid = s1_valid;
        st_d.ovf   = set_now;
        if (s1_valid) begin
            st_d.data = sum_hi[A_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign res_data  = st_q.data;
    assign res_ovf   = st_q.ovf;

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(res_data)); // R4
    AST_NO_MUL_OVF: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_acc == '0) |=> !res_ovf); // R9

endmodule

// File: rtl/wbm_sticky.sv
module wbm_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set |=> flag); // R7
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set) |=> !flag); // R5

endmodule

// File: rtl/wbm_mac.sv
module wbm_mac #(
    parameter int A_W = 32,
    parameter int H_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_cond,
    input  logic             in_half,
    input  logic [A_W-1:0]   in_a,
    input  logic [2*H_W-1:0] in_b,
    input  logic [A_W-1:0]   in_c,
    input  logic             flag_clr,
    output logic             res_valid,
    output logic [A_W-1:0]   res_data,
    output logic             sat_flag
);
    logic           fire;
    logic [H_W-1:0] half_op;
    logic           s1_valid;
    logic [A_W-1:0] s1_phi;
    logic [A_W-1:0] s1_acc;
    logic           res_ovf;
    logic           set_now;
    logic [1:0]     age_d, age_q;

    assign fire = in_valid & in_cond;

    wbm_half_pick #(.H_W(H_W)) pick_i (
        .word (in_b),
        .sel  (in_half),
        .half (half_op)
    );

    wbm_mul_stage #(.A_W(A_W), .H_W(H_W)) mul_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .op_a     (in_a),
        .op_h     (half_op),
        .op_c     (in_c),
        .s1_valid (s1_valid),
        .s1_phi   (s1_phi),
        .s1_acc   (s1_acc)
    );

    wbm_acc_stage #(.A_W(A_W)) acc_i (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_phi    (s1_phi),
        .s1_acc    (s1_acc),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_ovf   (res_ovf),
        .set_now   (set_now)
    );

    wbm_sticky sticky_i (
        .clk  (clk),
        .rst  (rst),
        .set  (set_now),
        .clr  (flag_clr),
        .flag (sat_flag)
    );

    // Cycles since reset, saturating, so latency checks never look before reset.
    always_comb begin
        age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 2'd0;
        end else begin
            age_q <= age_d;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (res_valid == $past(fire, 2))); // R3
    AST_FLAG_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ovf) |-> sat_flag); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (!sat_flag || (res_valid && res_ovf))); // R6
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !sat_flag && res_data == '0)); // R8

endmodule

// File: tb/wbm_mac_tb.sv
module wbm_mac_tb_top;

    localparam int A_W = 6;
    localparam int H_W = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_cond = 1'b0;
    logic           in_half = 1'b0;
    logic [A_W-1:0] in_a = '0;
    logic [2*H_W-1:0] in_b = '0;
    logic [A_W-1:0] in_c = '0;
    logic           flag_clr = 1'b0;
    logic           res_valid;
    logic [A_W-1:0] res_data;
    logic           sat_flag;

    int total = 0;
    int bad = 0;

    // Model state: index 0 is the newest applied input, index 1 the one before.
    logic p_v [2];
    int   p_d [2];
    logic p_o [2];
    logic clr_prev;
    logic flag_m;
    int   last_d;

    always #2 clk = ~clk;

    wbm_mac #(.A_W(A_W), .H_W(H_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_cond   (in_cond),
        .in_half   (in_half),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_c      (in_c),
        .flag_clr  (flag_clr),
        .res_valid (res_valid),
        .res_data  (res_data),
        .sat_flag  (sat_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    task automatic model_reset();
        p_v[0] = 1'b0; p_v[1] = 1'b0;
        p_d[0] = 0;    p_d[1] = 0;
        p_o[0] = 1'b0; p_o[1] = 1'b0;
        clr_prev = 1'b0;
        flag_m = 1'b0;
        last_d = 0;
    endtask

    // One cycle: check outputs at the falling edge, then drive the next inputs.
    task automatic step(input logic v, input logic cond, input logic sel,
                        input int a, input int b, input int c, input logic clr);
        int hv;
        int full;
        int hi;
        int res;
        @(negedge clk);
        flag_m = (flag_m & ~clr_prev) | (p_v[1] & p_o[1]);
        chk("R3 R4 res_valid", int'(res_valid), int'(p_v[1]));
        if (p_v[1]) begin
            chk("R1 R2 res_data", int'(res_data), p_d[1]);
            last_d = p_d[1];
        end else begin
            chk("R4 res_data hold", int'(res_data), last_d);
        end
        chk("R5 R6 R7 R9 sat_flag", int'(sat_flag), int'(flag_m));
        hv   = sel ? ((b >> H_W) & 7) : (b & 7);
        full = sx(a, A_W) * sx(hv, H_W) + sx(c, A_W) * (1 << H_W);
        hi   = full >>> H_W;
        res  = hi & ((1 << A_W) - 1);
        p_v[1] = p_v[0]; p_d[1] = p_d[0]; p_o[1] = p_o[0];
        p_v[0] = v & cond;
        p_d[0] = res;
        p_o[0] = (sx(res, A_W) != hi);
        clr_prev = clr;
        in_valid = v; in_cond = cond; in_half = sel;
        in_a = A_W'(a); in_b = (2*H_W)'(b); in_c = A_W'(c); flag_clr = clr;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; flag_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cset [6] = '{0, 32, 31, 5, 63, 17};
        int cnt = 0;
        model_reset();
        do_reset();
        #1;
        chk("R8 reset res_valid", int'(res_valid), 0);
        chk("R8 reset sat_flag", int'(sat_flag), 0);
        chk("R8 reset res_data", int'(res_data), 0);

        // Sweep: the first pass uses in_c = 0 (R9), then overflow-prone values.
        for (int ci = 0; ci < 6; ci++) begin
            for (int ai = 0; ai < 64; ai++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int h = 0; h < 8; h++) begin
                        int junk = int'($urandom_range(7));
                        int b = (s == 1) ? ((h << H_W) | junk) : ((junk << H_W) | h);
                        logic v = (cnt % 11) != 10;
                        logic cond = (cnt % 13) != 7;
                        logic clr = (cnt % 97) == 0;
                        step(v, cond, s[0], ai, b, cset[ci], clr);
                        cnt++;
                    end
                end
            end
        end
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk("R6 flag cleared", int'(sat_flag), 0);

        // R7: overflowing result (31*3 + 31<<3) meets a clear at the same edge.
        step(1'b1, 1'b1, 1'b0, 31, 3, 31, 1'b0);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b1);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0);
        chk("R7 set wins over clear", int'(sat_flag), 1);

        // R4: the same overflowing input with condition failed changes nothing.
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 31, 3, 31, 1'b0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk("R4 cond low keeps flag", int'(sat_flag), 0);

        // R8: reset while the flag is set.
        step(1'b1, 1'b1, 1'b1, 31, 24, 31, 1'b0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        chk("R5 flag set before reset", int'(sat_flag), 1);
        do_reset();
        #1;
        chk("R8 mid-run reset sat_flag", int'(sat_flag), 0);
        chk("R8 mid-run reset res_valid", int'(res_valid), 0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule